// File: doc/BRIEF.md
# Match/Capture Timer with Prescaler

This block is a general-purpose timer for a peripheral subsystem. A counter of up to 32 bits advances once every time a programmable prescaler wraps, so software can trade resolution against range. Four compare registers watch the counter. Each one can, on its own, flag an interrupt, return the counter to zero or halt it. Each also drives one output pin that can be forced low, forced high, inverted or left alone when its compare value is reached.

Four capture inputs are brought into the clock domain with two flip-flops. Each one can snapshot the counter on a rising edge, a falling edge or both. Instead of the clock, a counter mode can step the prescaler on edges of one chosen capture input, which makes the block count external events. Software reaches every register through a simple single-cycle write port and a combinational read port. Interrupt flags stay set until software writes a 1 to clear them.

Register addresses (5-bit word address): 0 control, 1 flags, 2 counter, 3 prescale limit, 4 prescale count (read only), 5 compare actions, 6 capture config, 7 output control, 16+i compare value i, 24+j capture value j.

Top module: `match_capture_timer`

## Requirements
- R1: With run set (control bit 0) and hold clear, the prescale count goes from 0 up to the prescale limit P and then wraps. The counter advances by one on each wrap, that is once every P+1 clocks. With run clear the counter does not move.
- R2: If compare i has its reset action set (compare-action bit 3i+1) and a step occurs while the counter equals compare value Mi, the counter goes to 0 instead of Mi+1. The counter period is therefore Mi+1 steps.
- R3: If compare i has its stop action set (compare-action bit 3i+2) and a step occurs while the counter equals Mi, the counter stays at Mi and control bit 0 (run) reads back 0.
- R4: If compare i has its interrupt action set (compare-action bit 3i), the step at equality sets flag bit i. Capture j with its interrupt bit set (capture-config bit 3j+2) sets flag bit 8+j. Flags stay set until a 1 is written to that bit of the flags register, and a new event in the same cycle wins over the clear. The irq output is high while any flag is set.
- R5: Output control bits 2i+9:2i+8 choose what compare i does to match_out[i] on its event: 00 leaves it unchanged, 01 drives 0, 10 drives 1, 11 inverts it. A write to output control loads match_out from bits N-1:0.
- R6: Capture-config bits 3j (rising edge) and 3j+1 (falling edge) choose which edges of cap_in[j] copy the counter into capture register j, three clocks after the pin changes. An edge that is not selected leaves the capture register unchanged.
- R7: In counter mode (control bit 2), the prescaler steps only on edges of cap_in[sel]. sel is in control bits 5 and up. The edges are chosen by control bits 4:3 (bit 3 rising, bit 4 falling). With P=0, every selected edge adds one to the counter.
- R8: While hold (control bit 1) is set, the counter and the prescale count are held at 0.
- R9: After reset the counter, the control register, the flags, match_out and irq are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr | input | 1 | Register write strobe |
| addr | input | 5 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| cap_in | input | N_CAP | Capture / count pins, asynchronous |
| match_out | output | N_MATCH | Compare-driven output pins |
| irq | output | 1 | Interrupt request, OR of all flags |

## Verification
The bench uses the default parameters: a 32-bit counter, four compare channels and four capture channels. This gives access to every compare action code and to the highest counter-mode select value, 3. The table loop changes the prescale limit and the reset compare value over several values, including the degenerate compare value 0. The directed tests cover stop-on-match, the four output actions, edge-selective capture and event counting on one and on both edges.

// File: rtl/match_capture_timer.sv
module match_capture_timer #(
  parameter int CNT_W   = 32,
  parameter int N_MATCH = 4,
  parameter int N_CAP   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [4:0]         addr,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  input  logic [N_CAP-1:0]   cap_in,
  output logic [N_MATCH-1:0] match_out,
  output logic               irq
);
  localparam int SEL_W = (N_CAP > 1) ? $clog2(N_CAP) : 1;

  logic               run_q, hold_q, cmode_q;
  logic [1:0]         cedge_q;
  logic [SEL_W-1:0]   csel_q;
  logic [CNT_W-1:0]   tc_q, pr_q, pc_q;
  logic [3*N_MATCH-1:0] mact_q;
  logic [3*N_CAP-1:0]   ccfg_q;
  logic [2*N_MATCH-1:0] mext_q;
  logic [N_MATCH-1:0] mout_q, mflag_q;
  logic [N_CAP-1:0]   cflag_q;
  logic [CNT_W-1:0]   mr_q [N_MATCH];
  logic [CNT_W-1:0]   cr_q [N_CAP];
  logic [N_CAP-1:0]   s1_q, s2_q, s3_q;

  logic w_ctrl, w_flag, w_cnt, w_pr, w_mact, w_ccfg, w_ext;
  assign w_ctrl = wr && addr == 5'd0;
  assign w_flag = wr && addr == 5'd1;
  assign w_cnt  = wr && addr == 5'd2;
  assign w_pr   = wr && addr == 5'd3;
  assign w_mact = wr && addr == 5'd5;
  assign w_ccfg = wr && addr == 5'd6;
  assign w_ext  = wr && addr == 5'd7;

  logic [N_CAP-1:0] rise, fall, cap_hit, cap_irq;
  assign rise = s2_q & ~s3_q;
  assign fall = ~s2_q & s3_q;

  logic cnt_edge, step, tick;
  assign cnt_edge = (cedge_q[0] & rise[csel_q]) | (cedge_q[1] & fall[csel_q]);
  assign step     = run_q && !hold_q && (cmode_q ? cnt_edge : 1'b1);
  assign tick     = step && (pc_q == pr_q);

  logic [N_MATCH-1:0] eq, mev, mirq_en, mrst_en, mstop_en;
  always_comb begin
    for (int i = 0; i < N_MATCH; i++) begin
      eq[i]       = tc_q == mr_q[i];
      mirq_en[i]  = mact_q[3*i];
      mrst_en[i]  = mact_q[3*i+1];
      mstop_en[i] = mact_q[3*i+2];
    end
    for (int j = 0; j < N_CAP; j++) begin
      cap_hit[j] = (ccfg_q[3*j] & rise[j]) | (ccfg_q[3*j+1] & fall[j]);
      cap_irq[j] = ccfg_q[3*j+2] & cap_hit[j];
    end
  end
  assign mev = {N_MATCH{tick}} & eq;

  logic do_rst, do_stop;
  assign do_rst  = |(mev & mrst_en);
  assign do_stop = |(mev & mstop_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0; hold_q <= 1'b0; cmode_q <= 1'b0;
      cedge_q <= '0; csel_q <= '0;
    end else if (w_ctrl) begin
      run_q   <= wdata[0];
      hold_q  <= wdata[1];
      cmode_q <= wdata[2];
      cedge_q <= wdata[4:3];
      csel_q  <= wdata[5 +: SEL_W];
    end else if (do_stop) begin
      run_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tc_q <= '0;
    else if (hold_q) tc_q <= '0;
    else if (w_cnt)  tc_q <= wdata[CNT_W-1:0];
    else if (tick) begin
      if (do_rst)       tc_q <= '0;
      else if (!do_stop) tc_q <= tc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pc_q <= '0;
    else if (hold_q) pc_q <= '0;
    else if (step)   pc_q <= (pc_q == pr_q) ? '0 : pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pr_q <= '0; mact_q <= '0; ccfg_q <= '0; mext_q <= '0;
      s1_q <= '0; s2_q <= '0; s3_q <= '0;
    end else begin
      if (w_pr)   pr_q   <= wdata[CNT_W-1:0];
      if (w_mact) mact_q <= wdata[3*N_MATCH-1:0];
      if (w_ccfg) ccfg_q <= wdata[3*N_CAP-1:0];
      if (w_ext)  mext_q <= wdata[8 +: 2*N_MATCH];
      s1_q <= cap_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mout_q <= '0;
      for (int i = 0; i < N_MATCH; i++) mr_q[i] <= '0;
    end else begin
      for (int i = 0; i < N_MATCH; i++) begin
        if (wr && addr == 5'(16 + i)) mr_q[i] <= wdata[CNT_W-1:0];
        if (w_ext) mout_q[i] <= wdata[i];
        else if (mev[i]) begin
          case (mext_q[2*i +: 2])
            2'b01:   mout_q[i] <= 1'b0;
            2'b10:   mout_q[i] <= 1'b1;
            2'b11:   mout_q[i] <= ~mout_q[i];
            default: mout_q[i] <= mout_q[i];
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < N_CAP; j++) cr_q[j] <= '0;
    end else begin
      for (int j = 0; j < N_CAP; j++)
        if (cap_hit[j]) cr_q[j] <= tc_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mflag_q <= '0;
      cflag_q <= '0;
    end else begin
      mflag_q <= (mflag_q & ~(w_flag ? wdata[N_MATCH-1:0] : '0)) | (mev & mirq_en);
      cflag_q <= (cflag_q & ~(w_flag ? wdata[8 +: N_CAP] : '0)) | cap_irq;
    end
  end

  assign match_out = mout_q;
  assign irq       = |mflag_q || |cflag_q;

  always_comb begin
    rdata = '0;
    case (addr)
      5'd0: rdata = 32'({csel_q, cedge_q, cmode_q, hold_q, run_q});
      5'd1: begin
        rdata[N_MATCH-1:0] = mflag_q;
        rdata[8 +: N_CAP]  = cflag_q;
      end
      5'd2: rdata = 32'(tc_q);
      5'd3: rdata = 32'(pr_q);
      5'd4: rdata = 32'(pc_q);
      5'd5: rdata = 32'(mact_q);
      5'd6: rdata = 32'(ccfg_q);
      5'd7: begin
        rdata[N_MATCH-1:0]     = mout_q;
        rdata[8 +: 2*N_MATCH]  = mext_q;
      end
      default: begin
        for (int i = 0; i < N_MATCH; i++)
          if (addr == 5'(16 + i)) rdata = 32'(mr_q[i]);
        for (int j = 0; j < N_CAP; j++)
          if (addr == 5'(24 + j)) rdata = 32'(cr_q[j]);
      end
    endcase
  end
endmodule

// File: rtl/match_capture_timer_chk.sv
module match_capture_timer_chk #(
  parameter int CNT_W   = 32,
  parameter int N_MATCH = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr,
  input logic [4:0]         addr,
  input logic               irq,
  input logic [N_MATCH-1:0] match_out,
  input logic               run_q,
  input logic               hold_q,
  input logic               tick,
  input logic [CNT_W-1:0]   tc_q,
  input logic [N_MATCH-1:0] mev,
  input logic [N_MATCH-1:0] mrst_en,
  input logic [N_MATCH-1:0] mstop_en
);
  AST_HOLD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |=> tc_q == '0); // R8

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !hold_q && !(wr && addr == 5'd2)) |=> $stable(tc_q)); // R1

  AST_RESET_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (|(mev & mrst_en) && !(wr && addr == 5'd2)) |=> tc_q == '0); // R2

  AST_STOP_CLEARS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (|(mev & mstop_en) && !(wr && addr == 5'd0)) |=> !run_q); // R3

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(wr && addr == 5'd1)) |=> irq); // R4

  AST_OUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !(wr && addr == 5'd7)) |=> $stable(match_out)); // R5
endmodule

bind match_capture_timer match_capture_timer_chk #(.CNT_W(CNT_W), .N_MATCH(N_MATCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr(wr), .addr(addr), .irq(irq),
  .match_out(match_out), .run_q(run_q), .hold_q(hold_q), .tick(tick),
  .tc_q(tc_q), .mev(mev), .mrst_en(mrst_en), .mstop_en(mstop_en)
);

// File: tb/test_match_capture_timer.sv
`timescale 1ns/1ps
module test_match_capture_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  cap_in = '0;
  logic [3:0]  match_out;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  match_capture_timer i_match_capture_timer (
    .clk(clk), .rst_n(rst_n), .wr(wr), .addr(addr), .wdata(wdata),
    .rdata(rdata), .cap_in(cap_in), .match_out(match_out), .irq(irq)
  );

  // prescale limit, compare value, clocks to wait, expected counter
  localparam int VEC [6][4] = '{
    '{0, 9,   5,  5},
    '{0, 3,  10,  2},
    '{2, 100, 10, 3},
    '{3, 2,  20,  2},
    '{1, 4,  11,  0},
    '{0, 0,   7,  0}
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rreg(input logic [4:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int bitn, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); cap_in[bitn] = 1'b1;
      waitc(2);       cap_in[bitn] = 1'b0;
      waitc(1);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    waitc(3);
    rst_n = 1'b1;
    waitc(1);

    // R9 reset state
    rreg(5'd2, d); chk(d, 0, "R9 counter");
    rreg(5'd0, d); chk(d, 0, "R9 control");
    chk(32'(match_out), 0, "R9 match_out");
    chk(32'(irq), 0, "R9 irq");

    // R1 R2 prescale and reset-on-match table
    for (int v = 0; v < 6; v++) begin
      wreg(5'd0, 32'h2);
      wreg(5'd3, VEC[v][0]);
      wreg(5'd16, VEC[v][1]);
      wreg(5'd5, 32'h2);
      wreg(5'd0, 32'h1);
      waitc(VEC[v][2]);
      rreg(5'd2, d);
      chk(d, VEC[v][3], $sformatf("R1 R2 vector %0d", v));
    end

    // R4 compare interrupt flag, sticky, write-1-clear
    wreg(5'd0, 32'h2);
    wreg(5'd3, 0);
    wreg(5'd16, 3);
    wreg(5'd5, 32'h3);
    wreg(5'd1, 32'hFFFF_FFFF);
    wreg(5'd0, 32'h1);
    waitc(10);
    chk(32'(irq), 1, "R4 irq raised");
    wreg(5'd0, 32'h0);
    rreg(5'd1, d); chk(d & 32'h1, 1, "R4 flag bit0 held");
    wreg(5'd1, 32'h1);
    waitc(1);
    chk(32'(irq), 0, "R4 irq cleared");

    // R3 stop on match
    wreg(5'd0, 32'h2);
    wreg(5'd17, 6);
    wreg(5'd5, 32'h20);
    wreg(5'd0, 32'h1);
    waitc(20);
    rreg(5'd2, d); chk(d, 6, "R3 counter holds at compare");
    rreg(5'd0, d); chk(d & 1, 0, "R3 run cleared");

    // R5 output actions
    wreg(5'd0, 32'h2);
    wreg(5'd5, 32'h0);
    wreg(5'd17, 5);
    wreg(5'd18, 2);
    wreg(5'd19, 4);
    wreg(5'd7, 32'h0000_B402);
    chk(32'(match_out), 32'h2, "R5 load levels");
    wreg(5'd0, 32'h1);
    waitc(10);
    chk(32'(match_out), 32'hC, "R5 low/high/toggle/none");

    // R6 capture
    wreg(5'd0, 32'h0);
    wreg(5'd1, 32'hFFFF_FFFF);
    wreg(5'd2, 32'h1234);
    wreg(5'd6, 32'hE8);
    @(negedge clk); cap_in[1] = 1'b1;
    waitc(5);
    rreg(5'd25, d); chk(d, 32'h1234, "R6 rising capture ch1");
    rreg(5'd1, d);  chk(d & 32'h200, 32'h200, "R4 capture flag ch1");
    wreg(5'd2, 32'h55);
    cap_in[1] = 1'b0;
    waitc(5);
    rreg(5'd25, d); chk(d, 32'h1234, "R6 falling edge ignored ch1");
    cap_in[2] = 1'b1;
    waitc(5);
    rreg(5'd26, d); chk(d, 32'h55, "R6 both-edge capture rise ch2");
    wreg(5'd2, 32'h77);
    cap_in[2] = 1'b0;
    waitc(5);
    rreg(5'd26, d); chk(d, 32'h77, "R6 both-edge capture fall ch2");
    rreg(5'd1, d);  chk(d & 32'h400, 0, "R4 no flag without capture irq");

    // R7 counter mode
    wreg(5'd0, 32'h2);
    wreg(5'd3, 0);
    wreg(5'd5, 0);
    wreg(5'd0, 32'd109);
    pulse(3, 5);
    waitc(5);
    rreg(5'd2, d); chk(d, 5, "R7 rising edges counted");
    wreg(5'd0, 32'h2);
    wreg(5'd0, 32'd125);
    pulse(3, 3);
    waitc(5);
    rreg(5'd2, d); chk(d, 6, "R7 both edges counted");

    // R8 hold
    wreg(5'd0, 32'h3);
    waitc(6);
    rreg(5'd2, d); chk(d, 0, "R8 counter held");
    rreg(5'd4, d); chk(d, 0, "R8 prescale held");

    done = 1;
    finish_run();
  end
endmodule